// File: doc/BRIEF.md
# Twiddle Index Generator

This block walks one DFT output bin through its whole input pass. It takes a transform size N and a fixed bin index k. On a start pulse it steps a sample counter n from 0 to N-1, one step per clock. For each step it emits the twiddle lookup address (n·k) mod N. N is any value from 1 to 1024 and does not need to be a power of two. No multiplier or divider is used: a running index adds k on each step and subtracts N once whenever the sum reaches or passes N.

The address feeds a built-in cosine/sine table whose contents are computed when the design is elaborated. One address selects both values. Each value is a signed 32-bit fixed-point word with 30 fraction bits. The table describes a circle of `TBL_N` points (a parameter, 1000 by default), so the angles are exact when the run-time N equals `TBL_N`.

The table output is registered. The cosine/sine pair and its own valid and last flags appear one cycle after the address.

Top module: `twid_index_gen`

## Requirements
- R1: While reset is high and on the first cycle after it, `addr_vld_o` and `tw_vld_o` are low.
- R2: A start pulse is accepted when the block is idle, 1 ≤ N ≤ 1024 and k < N. The cycle after an accepted start, `addr_vld_o` rises with address 0. It then stays high for exactly N consecutive cycles.
- R3: On the cycle where `addr_vld_o` is high for step n, `addr_o` equals (n·k) mod N. This holds for non-power-of-two N as well.
- R4: `addr_last_o` is high on exactly one cycle of a pass, the one for step n = N-1. `addr_vld_o` is low on the cycle after it.
- R5: With k = 0, every address of the pass is 0.
- R6: N and k are sampled at the accepted start. Changes to `size_i` or `k_i` during a pass have no effect on that pass, and neither do further start pulses.
- R7: A start pulse with N = 0, N > 1024, or k ≥ N is ignored: no valid address follows.
- R8: One cycle after each valid address, `tw_vld_o` is high. In that same cycle `tw_last_o` equals the address-stage last flag. `cos_o` and `sin_o` equal round(cos(2π·a/TBL_N)·2^30) and round(sin(2π·a/TBL_N)·2^30) as signed 32-bit values, where a is that address. Rounding is half away from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a pass |
| size_i | input | 11 | Transform size N |
| k_i | input | 10 | Output bin index k |
| addr_o | output | 10 | Table address (n·k) mod N |
| addr_vld_o | output | 1 | Address valid |
| addr_last_o | output | 1 | Address is for n = N-1 |
| cos_o | output | 32 | Cosine word, signed, 30 fraction bits |
| sin_o | output | 32 | Sine word, signed, 30 fraction bits |
| tw_vld_o | output | 1 | Cosine/sine valid |
| tw_last_o | output | 1 | Cosine/sine pair is the last of the pass |

## Verification
The hardest condition to reach is the wrap at the top of the range. With N = 1024 and k = 1023, the running sum nears 2N and must subtract N on almost every step, which exercises the full width of the index arithmetic. The stimulus drives that pass in full. It also drives a non-power-of-two N of 1000 and a pass where size, bin and start all toggle while the pass runs. A behavioural model, using a true multiply and modulo, is compared against the outputs on every cycle.

// File: rtl/twid_pkg.sv
package twid_pkg;
  localparam int ADDR_W = 10;
  localparam int DATA_W = 32;
  localparam int FRAC_W = 30;

  // round half away from zero to a signed fixed-point word
  function automatic logic signed [DATA_W-1:0] to_fixed(real v);
    real s;
    s = v * (2.0 ** FRAC_W);
    if (s >= 0.0) return DATA_W'($rtoi(s + 0.5));
    else          return DATA_W'($rtoi(s - 0.5));
  endfunction
endpackage

// File: rtl/twid_step_ctrl.sv
module twid_step_ctrl #(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic [AW:0]   size_i,
  input  logic [AW-1:0] k_i,
  output logic [AW-1:0] addr_o,
  output logic          vld_o,
  output logic          last_o
);
  localparam int SW = AW + 1;
  localparam logic [SW-1:0] MAX_N = SW'(2 ** AW);

  logic          busy_q, last_q;
  logic [AW-1:0] n_q, idx_q, k_q, lim_q;
  logic [SW-1:0] size_q;
  logic [SW-1:0] sum, wrapped;
  logic          accept;

  assign accept  = !busy_q && start_i && (size_i != '0) && (size_i <= MAX_N)
                   && ({1'b0, k_i} < size_i);
  assign sum     = {1'b0, idx_q} + {1'b0, k_q};
  assign wrapped = (sum >= size_q) ? (sum - size_q) : sum;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      last_q <= 1'b0;
      n_q    <= '0;
      idx_q  <= '0;
      k_q    <= '0;
      lim_q  <= '0;
      size_q <= '0;
    end else if (accept) begin
      busy_q <= 1'b1;
      n_q    <= '0;
      idx_q  <= '0;
      k_q    <= k_i;
      size_q <= size_i;
      lim_q  <= AW'(size_i - SW'(1));
      last_q <= (size_i == SW'(1));
    end else if (busy_q) begin
      if (last_q) begin
        busy_q <= 1'b0;
        last_q <= 1'b0;
      end else begin
        n_q    <= n_q + AW'(1);
        idx_q  <= wrapped[AW-1:0];
        last_q <= ((n_q + AW'(1)) == lim_q);
      end
    end
  end

  assign addr_o = idx_q;
  assign vld_o  = busy_q;
  assign last_o = last_q;

  AST_FIRST_ADDR_ZERO: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_q) |-> idx_q == '0); // R2
  AST_ADDR_BELOW_N: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> {1'b0, idx_q} < size_q); // R3
  AST_LAST_ENDS_PASS: assert property (@(posedge clk) disable iff (rst)
    last_q |=> !busy_q); // R4
  AST_ZERO_BIN_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (busy_q && k_q == '0) |-> idx_q == '0); // R5
  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !last_q) |=> ($stable(size_q) && $stable(k_q))); // R6
endmodule

// File: rtl/twid_sincos_rom.sv
module twid_sincos_rom
  import twid_pkg::*;
#(
  parameter int AW    = 10,
  parameter int DW    = 32,
  parameter int TBL_N = 1000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] addr_i,
  input  logic          vld_i,
  input  logic          last_i,
  output logic [DW-1:0] cos_o,
  output logic [DW-1:0] sin_o,
  output logic          vld_o,
  output logic          last_o
);
  localparam int  DEPTH = 2 ** AW;
  localparam real TWO_PI = 6.28318530717958647692;

  logic [DW-1:0] cos_mem [DEPTH];
  logic [DW-1:0] sin_mem [DEPTH];
  logic [DW-1:0] cos_q, sin_q;
  logic          vld_q, last_q;

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      cos_mem[i] = DW'(to_fixed($cos(TWO_PI * i / TBL_N)));
      sin_mem[i] = DW'(to_fixed($sin(TWO_PI * i / TBL_N)));
    end
  end

  always_ff @(posedge clk) begin
    if (vld_i) begin
      cos_q <= cos_mem[addr_i];
      sin_q <= sin_mem[addr_i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q  <= 1'b0;
      last_q <= 1'b0;
    end else begin
      vld_q  <= vld_i;
      last_q <= vld_i && last_i;
    end
  end

  assign cos_o  = cos_q;
  assign sin_o  = sin_q;
  assign vld_o  = vld_q;
  assign last_o = last_q;

  AST_DATA_FOLLOWS_ADDR: assert property (@(posedge clk) disable iff (rst)
    vld_i |=> vld_o); // R8
  AST_NO_SPURIOUS_DATA: assert property (@(posedge clk) disable iff (rst)
    !vld_i |=> !vld_o); // R8
endmodule

// File: rtl/twid_index_gen.sv
module twid_index_gen #(
  parameter int AW    = 10,
  parameter int DW    = 32,
  parameter int TBL_N = 1000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic [AW:0]   size_i,
  input  logic [AW-1:0] k_i,
  output logic [AW-1:0] addr_o,
  output logic          addr_vld_o,
  output logic          addr_last_o,
  output logic [DW-1:0] cos_o,
  output logic [DW-1:0] sin_o,
  output logic          tw_vld_o,
  output logic          tw_last_o
);
  twid_step_ctrl #(.AW(AW)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .start_i (start_i),
    .size_i  (size_i),
    .k_i     (k_i),
    .addr_o  (addr_o),
    .vld_o   (addr_vld_o),
    .last_o  (addr_last_o)
  );

  twid_sincos_rom #(.AW(AW), .DW(DW), .TBL_N(TBL_N)) u_rom (
    .clk    (clk),
    .rst    (rst),
    .addr_i (addr_o),
    .vld_i  (addr_vld_o),
    .last_i (addr_last_o),
    .cos_o  (cos_o),
    .sin_o  (sin_o),
    .vld_o  (tw_vld_o),
    .last_o (tw_last_o)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    $past(rst) |-> (!addr_vld_o && !tw_vld_o)); // R1
endmodule

// File: tb/tb_twid_index_gen.sv
`timescale 1ns/1ps
module tb_twid_index_gen;
  localparam int TBL = 1000;
  localparam real PI2 = 2.0 * 3.14159265358979323846;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic [10:0] size_i = '0;
  logic [9:0]  k_i = '0;
  logic [9:0]  addr_o;
  logic        addr_vld_o, addr_last_o, tw_vld_o, tw_last_o;
  logic [31:0] cos_o, sin_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  twid_index_gen #(.TBL_N(TBL)) dut (
    .clk(clk), .rst(rst), .start_i(start_i), .size_i(size_i), .k_i(k_i),
    .addr_o(addr_o), .addr_vld_o(addr_vld_o), .addr_last_o(addr_last_o),
    .cos_o(cos_o), .sin_o(sin_o), .tw_vld_o(tw_vld_o), .tw_last_o(tw_last_o)
  );

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int fixq(real v);
    real s = v * 1073741824.0;
    int r;
    if (s < 0.0) r = -$rtoi(-s + 0.5);
    else         r = $rtoi(s + 0.5);
    return r;
  endfunction

  // behavioural reference
  bit m_busy, m_vld, m_last, m_tvld, m_tlast;
  int m_n, m_N, m_K, m_addr, m_taddr;

  always @(posedge clk) begin
    m_tvld  = m_vld;
    m_tlast = m_vld && m_last;
    m_taddr = m_addr;
    if (rst) begin
      m_busy = 0; m_tvld = 0; m_tlast = 0;
      m_n = 0; m_N = 1; m_K = 0;
    end else if (m_busy) begin
      if (m_n == m_N - 1) m_busy = 0;
      else m_n++;
    end else if (start_i && size_i >= 1 && size_i <= 1024 && int'(k_i) < int'(size_i)) begin
      m_busy = 1; m_n = 0; m_N = int'(size_i); m_K = int'(k_i);
    end
    m_vld  = m_busy;
    m_addr = (m_n * m_K) % m_N;
    m_last = m_busy && (m_n == m_N - 1);
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      check(addr_vld_o == m_vld, "R2", "addr_vld", addr_vld_o, m_vld);
      if (m_vld) begin
        check(addr_o == m_addr, "R3", "addr", addr_o, m_addr);
        check(addr_last_o == m_last, "R4", "addr_last", addr_last_o, m_last);
      end
      check(tw_vld_o == m_tvld, "R8", "tw_vld", tw_vld_o, m_tvld);
      if (m_tvld) begin
        check($signed(cos_o) == fixq($cos(PI2 * m_taddr / TBL)), "R8", "cos",
              $signed(cos_o), fixq($cos(PI2 * m_taddr / TBL)));
        check($signed(sin_o) == fixq($sin(PI2 * m_taddr / TBL)), "R8", "sin",
              $signed(sin_o), fixq($sin(PI2 * m_taddr / TBL)));
        check(tw_last_o == m_tlast, "R8", "tw_last", tw_last_o, m_tlast);
      end
    end
  end

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  // runs one pass; returns counts of valid, last and nonzero addresses
  task automatic run_pass(int sz, int kk, bit disturb, output int nv, output int nl, output int nz);
    @(negedge clk);
    size_i = 11'(sz); k_i = 10'(kk); start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    nv = 0; nl = 0; nz = 0;
    while (addr_vld_o) begin
      nv++;
      if (addr_last_o) nl++;
      if (addr_o != 0) nz++;
      if (disturb) begin
        size_i = 11'(nv + 3); k_i = 10'(nv); start_i = nv[0];
      end
      @(negedge clk);
    end
    start_i = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    int nv, nl, nz;
    repeat (3) @(negedge clk);
    check(addr_vld_o == 0 && tw_vld_o == 0, "R1", "valid during reset", addr_vld_o, 0);
    rst = 1'b0;
    @(negedge clk);
    check(addr_vld_o == 0 && tw_vld_o == 0, "R1", "valid after reset", addr_vld_o, 0);

    run_pass(10, 3, 0, nv, nl, nz);
    check(nv == 10, "R2", "pass length N=10", nv, 10);
    check(nl == 1, "R4", "last count N=10", nl, 1);

    run_pass(1000, 7, 0, nv, nl, nz);
    check(nv == 1000, "R3", "pass length N=1000", nv, 1000);
    check(nl == 1, "R4", "last count N=1000", nl, 1);

    run_pass(1, 0, 0, nv, nl, nz);
    check(nv == 1 && nl == 1, "R2", "single-point pass", nv, 1);

    run_pass(12, 0, 0, nv, nl, nz);
    check(nz == 0, "R5", "nonzero addresses with k=0", nz, 0);
    check(nv == 12, "R5", "pass length k=0", nv, 12);

    run_pass(1024, 1023, 0, nv, nl, nz);
    check(nv == 1024, "R3", "pass length N=1024 k=1023", nv, 1024);

    run_pass(7, 5, 1, nv, nl, nz);
    check(nv == 7, "R6", "pass length with disturbed inputs", nv, 7);
    check(nl == 1, "R6", "last count with disturbed inputs", nl, 1);

    run_pass(0, 0, 0, nv, nl, nz);
    check(nv == 0, "R7", "start with N=0", nv, 0);
    run_pass(1025, 1, 0, nv, nl, nz);
    check(nv == 0, "R7", "start with N=1025", nv, 0);
    run_pass(10, 10, 0, nv, nl, nz);
    check(nv == 0, "R7", "start with k=N", nv, 0);
    repeat (3) @(negedge clk);
    check(addr_vld_o == 0 && tw_vld_o == 0, "R7", "idle after rejected starts", addr_vld_o, 0);

    summary();
    $finish;
  end
endmodule